// File: doc/BRIEF.md
# Halt Low-Power Mode Sequencer

This controller takes a small system into its deepest low-power state and brings it back out. When the processor's idle instruction raises a halt request, the system clock keeps running for a bounded drain window. This gives in-flight operations time to finish. The controller then gates the core and peripheral clocks, shuts the PLL down, and optionally stops the crystal oscillator, the internal oscillators and the watchdog clock.

A falling edge on the active-low wake pin starts the exit sequence. The edge only counts if a short guard time has passed since the request. The oscillator is re-enabled, and a programmable settle counter models its start-up time. Once the oscillator is stable, the core clock returns. A single-cycle wake interrupt follows if that interrupt is enabled. After every exit the PLL is reported unlocked until software confirms a relock.

The controller runs on an always-alive internal-oscillator clock `clk`. The crystal-select and watchdog-keep bits are captured when the request is accepted.

Top module: `halt_lpm_seq`

## Requirements
- R1: After reset every clock enable (system, peripheral, PLL, crystal, internal oscillator, watchdog) is 1, `wake_irq` is 0, `pll_relock_req` is 0, `pll_locked` is 1 and `wake_err` is 0.
- R2: A halt request in the running state keeps `sysclk_en` and `periph_clk_en` at 1 for 16 cycles, or for 1 cycle when `pipe_idle` is 1 in the cycle after the request. After that, system clock, peripheral clocks and PLL enable are all 0.
- R3: While halted, `xosc_en` equals the inverse of the `xtal_sel` value captured at the request (1 = crystal source, shut down).
- R4: While halted, `intosc_en` and `wdclk_en` both equal the `wd_keep` value captured at the request (1 = keep running).
- R5: A wake falling edge that reaches the detector fewer than 5 cycles after the request is ignored. A pin held low afterwards does not wake the block, and the enables stay at their halted values.
- R6: A wake falling edge passes a two-flop synchronizer and an edge detector. `xosc_en` rises 3 cycles after the pin falls. `sysclk_en` rises `settle_cycles` + 4 cycles after the pin falls, and only while the crystal enable is 1.
- R7: `wake_irq` is a one-cycle pulse in the cycle after the core clock returns, and it occurs only when `irq_en` is 1.
- R8: Every exit from halt sets `pll_relock_req` to 1. `pll_locked` stays 0 until a `pll_relock_done` pulse clears the request, and it is 0 whenever the PLL is off.
- R9: If the synchronized wake pin is high while the oscillator is still settling, `wake_err` becomes 1. The exit still completes, and the flag clears on the next accepted halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-alive internal-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request from the idle instruction |
| pipe_idle | input | 1 | Pipeline drained, ends the drain window early |
| wake_n | input | 1 | Asynchronous wake pin, active falling edge |
| wd_keep | input | 1 | 1 keeps internal oscillators and watchdog clock in halt |
| xtal_sel | input | 1 | 1 when the clock source is an external crystal or resonator |
| irq_en | input | 1 | Wake interrupt enable |
| settle_cycles | input | SETTLE_W | Oscillator settle count |
| pll_relock_done | input | 1 | Pulse confirming a completed PLL relock |
| sysclk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL power enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| intosc_en | output | 1 | Internal oscillator enable |
| wdclk_en | output | 1 | Watchdog clock enable |
| wake_irq | output | 1 | One-cycle wake interrupt |
| pll_relock_req | output | 1 | PLL must be relocked |
| pll_locked | output | 1 | PLL reported locked |
| wake_err | output | 1 | Wake pin released before oscillator was stable |

## Verification
The hardest case to reach is a wake edge that falls inside the guard window. It requires a short drain and a pin that drops almost at once, so that the synchronized edge reaches the detector while fewer than five cycles have passed. The bench gets there by raising `pipe_idle` with the request and pulling the pin low on the very next cycle. It then holds the pin low and confirms that the block stays halted. Only after releasing and re-dropping the pin does it expect a wake. The error path needs the pin released within a long settle count, so the bench uses a settle value of 20 and releases the pin after five cycles.

// File: rtl/halt_lpm_pkg.sv
package halt_lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_DRAIN       = 3'd1,
    ST_HALTED      = 3'd2,
    ST_OSC_START   = 3'd3,
    ST_CLK_RESTORE = 3'd4,
    ST_WAKE_IRQ    = 3'd5
  } lpm_state_e;
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall,
  output logic level
);
  logic [SYNC_STAGES:0] sh;

  // Chain resets to 1 so that an idle-high pin causes no edge at start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC_STAGES-1:0], pin_n};
  end

  assign level = sh[SYNC_STAGES-1];
  assign fall  = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];
endmodule

// File: rtl/lpm_count.sv
module lpm_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (en && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/halt_lpm_seq.sv
module halt_lpm_seq
  import halt_lpm_pkg::*;
#(
  parameter int DRAIN_CYC = 16,
  parameter int GUARD_CYC = 5,
  parameter int SETTLE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                pipe_idle,
  input  logic                wake_n,
  input  logic                wd_keep,
  input  logic                xtal_sel,
  input  logic                irq_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                pll_relock_done,
  output logic                sysclk_en,
  output logic                periph_clk_en,
  output logic                pll_en,
  output logic                xosc_en,
  output logic                intosc_en,
  output logic                wdclk_en,
  output logic                wake_irq,
  output logic                pll_relock_req,
  output logic                pll_locked,
  output logic                wake_err
);
  localparam int DW = $clog2(DRAIN_CYC + 1);
  localparam int GW = $clog2(GUARD_CYC + 1);

  lpm_state_e state, state_nx;
  logic cfg_xtal, cfg_wdk;
  logic wake_fall, wake_level;
  logic drain_done, guard_ok, osc_done;
  logic enter_halt, wake_go;

  assign enter_halt = (state == ST_RUN) && halt_req;
  assign wake_go    = (state == ST_HALTED) && wake_fall && guard_ok;

  lpm_wake_sync #(.SYNC_STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (wake_n),
    .fall  (wake_fall),
    .level (wake_level)
  );

  lpm_count #(.W(DW)) u_drain (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (enter_halt),
    .en    (state == ST_DRAIN),
    .limit (DW'(DRAIN_CYC - 1)),
    .done  (drain_done)
  );

  lpm_count #(.W(GW)) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (enter_halt),
    .en    ((state == ST_DRAIN) || (state == ST_HALTED)),
    .limit (GW'(GUARD_CYC)),
    .done  (guard_ok)
  );

  lpm_count #(.W(SETTLE_W)) u_osc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wake_go),
    .en    (state == ST_OSC_START),
    .limit (settle_cycles),
    .done  (osc_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:         if (halt_req) state_nx = ST_DRAIN;
      ST_DRAIN:       if (pipe_idle || drain_done) state_nx = ST_HALTED;
      ST_HALTED:      if (wake_go) state_nx = ST_OSC_START;
      ST_OSC_START:   if (osc_done) state_nx = ST_CLK_RESTORE;
      ST_CLK_RESTORE: state_nx = ST_WAKE_IRQ;
      ST_WAKE_IRQ:    state_nx = ST_RUN;
      default:        state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      cfg_xtal <= 1'b0;
      cfg_wdk  <= 1'b1;
    end else begin
      state <= state_nx;
      if (enter_halt) begin
        cfg_xtal <= xtal_sel;
        cfg_wdk  <= wd_keep;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_relock_req <= 1'b0;
      wake_err       <= 1'b0;
    end else begin
      if ((state == ST_OSC_START) && osc_done) pll_relock_req <= 1'b1;
      else if (pll_relock_done)                pll_relock_req <= 1'b0;
      if (enter_halt)
        wake_err <= 1'b0;
      else if ((state == ST_OSC_START) && !osc_done && wake_level)
        wake_err <= 1'b1;
    end
  end

  always_comb begin
    sysclk_en     = 1'b1;
    periph_clk_en = 1'b1;
    pll_en        = 1'b1;
    xosc_en       = 1'b1;
    intosc_en     = 1'b1;
    wdclk_en      = 1'b1;
    unique case (state)
      ST_HALTED: begin
        sysclk_en     = 1'b0;
        periph_clk_en = 1'b0;
        pll_en        = 1'b0;
        xosc_en       = ~cfg_xtal;
        intosc_en     = cfg_wdk;
        wdclk_en      = cfg_wdk;
      end
      ST_OSC_START: begin
        sysclk_en     = 1'b0;
        periph_clk_en = 1'b0;
        pll_en        = 1'b0;
      end
      default: ;
    endcase
  end

  assign wake_irq   = (state == ST_WAKE_IRQ) && irq_en;
  assign pll_locked = pll_en && !pll_relock_req;
endmodule

// File: rtl/halt_lpm_chk.sv
module halt_lpm_chk (
  input logic clk,
  input logic rst_n,
  input logic sysclk_en,
  input logic periph_clk_en,
  input logic pll_en,
  input logic xosc_en,
  input logic intosc_en,
  input logic wdclk_en,
  input logic wake_irq,
  input logic pll_relock_req,
  input logic pll_locked,
  input logic cfg_wdk
);
  AST_GATED_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_en |-> (!periph_clk_en && !pll_en)); // R2
  AST_WD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sysclk_en && !xosc_en && cfg_wdk) |-> (wdclk_en && intosc_en)); // R4
  AST_CORE_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_en) |-> xosc_en); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq); // R7
  AST_IRQ_AFTER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (sysclk_en && $past(sysclk_en))); // R7
  AST_RELOCK_HIDES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pll_relock_req |-> !pll_locked); // R8
  AST_NO_LOCK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !pll_locked); // R8
endmodule

bind halt_lpm_seq halt_lpm_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sysclk_en      (sysclk_en),
  .periph_clk_en  (periph_clk_en),
  .pll_en         (pll_en),
  .xosc_en        (xosc_en),
  .intosc_en      (intosc_en),
  .wdclk_en       (wdclk_en),
  .wake_irq       (wake_irq),
  .pll_relock_req (pll_relock_req),
  .pll_locked     (pll_locked),
  .cfg_wdk        (cfg_wdk)
);

// File: tb/halt_lpm_seq_test.sv
module halt_lpm_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, pipe_idle = 1'b0, wake_n = 1'b1, wd_keep = 1'b0;
  logic xtal_sel = 1'b0, irq_en = 1'b0, pll_relock_done = 1'b0;
  logic [7:0] settle_cycles = 8'd0;
  logic sysclk_en, periph_clk_en, pll_en, xosc_en, intosc_en, wdclk_en;
  logic wake_irq, pll_relock_req, pll_locked, wake_err;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  halt_lpm_seq uut (.*);

  // Fields: {pipe_idle, xtal_sel, wd_keep, irq_en, settle[7:0]}
  localparam logic [11:0] VEC [5] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 8'd3},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'd0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd7},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd12},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse halt; return negedges until periph clocks stop.
  task automatic do_halt(output int n);
    n = 0;
    halt_req = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      halt_req = 1'b0;
      if (!periph_clk_en && n == 0) n = i;
      if (n != 0) break;
    end
  endtask

  // Drop wake pin; return negedges until core clock returns; xosc seen at 3.
  task automatic do_wake(output int n, output int xo3);
    n = 0; xo3 = 0;
    wake_n = 1'b0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (i == 3) xo3 = int'(xosc_en);
      if (sysclk_en) begin n = i; break; end
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog all-R actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n, xo3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sysclk", sysclk_en, 1); chk("R1 periph", periph_clk_en, 1);
    chk("R1 pll", pll_en, 1); chk("R1 xosc", xosc_en, 1);
    chk("R1 intosc", intosc_en, 1); chk("R1 wd", wdclk_en, 1);
    chk("R1 irq", wake_irq, 0); chk("R1 relock", pll_relock_req, 0);
    chk("R1 locked", pll_locked, 1); chk("R1 err", wake_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[k]) begin
      {pipe_idle, xtal_sel, wd_keep, irq_en, settle_cycles} = VEC[k];
      do_halt(n);
      chk("R2 drain length", n, VEC[k][11] ? 2 : 17);
      chk("R2 sysclk off", sysclk_en, 0); chk("R2 pll off", pll_en, 0);
      chk("R3 xosc in halt", xosc_en, int'(!VEC[k][10]));
      chk("R4 intosc in halt", intosc_en, int'(VEC[k][9]));
      chk("R4 wd in halt", wdclk_en, int'(VEC[k][9]));
      chk("R8 locked off", pll_locked, 0);
      repeat (8) @(negedge clk);
      do_wake(n, xo3);
      chk("R6 xosc rise", xo3, 1);
      chk("R6 wake latency", n, int'(VEC[k][7:0]) + 4);
      @(negedge clk);
      chk("R7 irq pulse", wake_irq, int'(VEC[k][8]));
      @(negedge clk);
      chk("R7 irq ends", wake_irq, 0);
      chk("R8 relock req", pll_relock_req, 1); chk("R8 not locked", pll_locked, 0);
      wake_n = 1'b1; pll_relock_done = 1'b1;
      @(negedge clk);
      pll_relock_done = 1'b0;
      chk("R8 relocked", pll_locked, 1);
      chk("R9 no err", wake_err, 0);
      repeat (4) @(negedge clk);
    end

    // R5 guard window: edge lands 3 cycles after request
    pipe_idle = 1'b1; xtal_sel = 1'b1; wd_keep = 1'b0; settle_cycles = 8'd2; irq_en = 1'b1;
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0; wake_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 still halted", sysclk_en, 0);
    chk("R5 xosc untouched", xosc_en, 0);
    wake_n = 1'b1;
    repeat (4) @(negedge clk);
    do_wake(n, xo3);
    chk("R5 later edge wakes", n, 6);
    wake_n = 1'b1;
    repeat (2) @(negedge clk);
    pll_relock_done = 1'b1; @(negedge clk); pll_relock_done = 1'b0;

    // R9 pin released while settling
    pipe_idle = 1'b1; settle_cycles = 8'd20;
    do_halt(n);
    repeat (8) @(negedge clk);
    wake_n = 1'b0;
    repeat (5) @(negedge clk);
    wake_n = 1'b1;
    for (int i = 0; i < 60 && !sysclk_en; i++) @(negedge clk);
    chk("R9 exit completes", sysclk_en, 1);
    chk("R9 err set", wake_err, 1);
    repeat (3) @(negedge clk);
    do_halt(n);
    chk("R9 err cleared", wake_err, 0);
    finish_run();
  end
endmodule